// File: doc/BRIEF.md
# Control OUT Endpoint Transfer Tracker

This block keeps the receive-side accounting for the control endpoint of a device controller. Software loads one 32-bit register that holds three counters: how many SETUP packets may still arrive back to back, a one-bit count of data packets still expected into the receive FIFO, and the number of bytes left to move from the FIFO to system memory. The packet engine, the FIFO and the memory mover then report events, and the block counts each of the three down toward zero.

The fill side and the drain side are counted apart. A packet landing in the FIFO touches only the packet count. A packet leaving the FIFO for memory arrives as a valid/ready beat carrying its byte length, and that length comes off the byte budget. The transfer-complete interrupt depends only on the byte budget: it pulses for one cycle when a drain beat brings the budget from a nonzero value to zero. If software loads the budget with the endpoint's maximum packet size, this gives one interrupt per packet.

The drain beat obeys valid/ready rules. The source holds `drain_valid` and `drain_len` steady until a cycle in which `drain_ready` is also high, and the beat is taken at that clock edge. `drain_ready` is low only in a cycle when software writes the register, so a write never races a drain. The SETUP and packet-written inputs are plain one-cycle strobes and cannot be held back. Two sticky flags report a SETUP arriving with no allowance left and a packet arriving with the count already zero.

Top module: `ctrl_out_tsz_tracker`

## Requirements
- R1: After reset, `rd_data` is zero, `xfer_done`, `setup_ovf` and `pkt_err` are low, and `drain_ready` is high.
- R2: A write with `wr_en` high stores `wr_data` bits 30:29 as the SETUP allowance, bit 19 as the packet count and bits 6:0 as the byte budget. From the next cycle `rd_data` returns those fields in the same places, and every other bit of `rd_data` reads 0 whatever was written there.
- R3: A `setup_evt` strobe while the SETUP allowance is nonzero lowers it by one, visible on `rd_data` the next cycle.
- R4: A `setup_evt` strobe while the allowance is zero leaves it at zero and sets `setup_ovf`, which stays high until the next register write.
- R5: A `pkt_evt` strobe while the packet count is 1 clears it to 0 the next cycle.
- R6: A `pkt_evt` strobe while the packet count is 0 leaves it at 0 and sets `pkt_err`, which stays high until the next register write.
- R7: A drain beat taken (`drain_valid` and `drain_ready` both high) reduces the byte budget by `drain_len`. If `drain_len` is at least the budget, the budget becomes 0 and never wraps.
- R8: `xfer_done` is high for exactly one cycle, the first cycle in which `rd_data` shows a budget of zero after a drain beat took it from nonzero. A drain beat at a zero budget, or software writing a zero budget, gives no pulse.
- R9: In a cycle with `wr_en` high, the written value is loaded and any `setup_evt`, `pkt_evt` or drain request in that cycle has no effect on the register or the flags.
- R10: Every register write clears `setup_ovf` and `pkt_err`.
- R11: `drain_ready` is high exactly when `wr_en` is low. A drain request held through a write cycle is taken in the first following cycle without a write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Software write strobe for the register |
| wr_data | input | 32 | Software write value |
| rd_data | output | 32 | Current register value, reserved bits zero |
| setup_evt | input | 1 | One-cycle strobe: a SETUP packet was received |
| pkt_evt | input | 1 | One-cycle strobe: a data packet was written into the receive FIFO |
| drain_valid | input | 1 | A packet has been moved from the FIFO to memory |
| drain_ready | output | 1 | The drain beat is accepted at this edge when valid is high |
| drain_len | input | 7 | Byte length of the drained packet |
| xfer_done | output | 1 | One-cycle transfer-complete interrupt pulse |
| setup_ovf | output | 1 | Sticky: a SETUP packet arrived with no allowance left |
| pkt_err | output | 1 | Sticky: a packet was written with the packet count at zero |

## Verification
All counter state sits in the readable register, so a wrong decrement, a missed saturation or a lost write shows on `rd_data` in the cycle after the event that caused it. A completion pulse that is wrong in time or missing shows on `xfer_done` in that same cycle, checked against the zero budget. A flag set at the wrong time, or not held, shows on `setup_ovf` or `pkt_err` in the cycle after the strobe and stays visible until the next write. A write that collides with events is checked by seeing only the written value on `rd_data` one cycle later, and `drain_ready` low during the write.

// File: rtl/ctout_pkg.sv
package ctout_pkg;

  localparam int unsigned REG_W_DEF  = 32;
  localparam int unsigned SUP_LSB_DEF  = 29;
  localparam int unsigned SUP_W_DEF    = 2;
  localparam int unsigned PKT_LSB_DEF  = 19;
  localparam int unsigned PKT_W_DEF    = 1;
  localparam int unsigned SIZE_LSB_DEF = 0;
  localparam int unsigned SIZE_W_DEF   = 7;
  localparam int unsigned LEN_W_DEF    = 7;

  // Contiguous bit mask of width w starting at bit lsb.
  function automatic logic [63:0] fmask(input int unsigned lsb, input int unsigned w);
    logic [63:0] m;
    m = ((64'd1 << w) - 64'd1) << lsb;
    return m;
  endfunction

endpackage

// File: rtl/ctout_sat_dec.sv
// Saturating down-step for one counter field: next value and a marker
// for a step requested while the field is already zero.
module ctout_sat_dec #(
  parameter int unsigned W  = 7,
  parameter int unsigned DW = 7
) (
  input  logic [W-1:0]  cur,
  input  logic          dec,
  input  logic [DW-1:0] amt,
  output logic [W-1:0]  nxt,
  output logic          empty_hit
);

  localparam int unsigned CW = (W > DW) ? W : DW;

  logic [CW-1:0] cur_x;
  logic [CW-1:0] amt_x;
  logic [CW-1:0] diff_x;

  assign cur_x  = CW'(cur);
  assign amt_x  = CW'(amt);
  assign diff_x = cur_x - amt_x;

  always_comb begin
    nxt = cur;
    if (dec) begin
      if (amt_x >= cur_x) nxt = '0;
      else                nxt = W'(diff_x);
    end
  end

  assign empty_hit = dec && (cur == '0);

endmodule

// File: rtl/ctout_sticky.sv
// Sticky flag: set by hardware, cleared by a software write (clear wins).
module ctout_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= 1'b0;
    else if (clr) q <= 1'b0;
    else if (set) q <= 1'b1;
  end

endmodule

// File: rtl/ctout_regfile.sv
// Holds the register image; only bits in FMASK can ever change.
module ctout_regfile #(
  parameter int unsigned        REG_W = 32,
  parameter logic [REG_W-1:0]   FMASK = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic [REG_W-1:0] hw_img,
  output logic [REG_W-1:0] reg_q
);

  logic [REG_W-1:0] src;

  assign src = wr_en ? wr_data : hw_img;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reg_q <= '0;
    else        reg_q <= (reg_q & ~FMASK) | (src & FMASK);
  end

endmodule

// File: rtl/ctrl_out_tsz_tracker.sv
module ctrl_out_tsz_tracker #(
  parameter int unsigned REG_W    = ctout_pkg::REG_W_DEF,
  parameter int unsigned SUP_LSB  = ctout_pkg::SUP_LSB_DEF,
  parameter int unsigned SUP_W    = ctout_pkg::SUP_W_DEF,
  parameter int unsigned PKT_LSB  = ctout_pkg::PKT_LSB_DEF,
  parameter int unsigned PKT_W    = ctout_pkg::PKT_W_DEF,
  parameter int unsigned SIZE_LSB = ctout_pkg::SIZE_LSB_DEF,
  parameter int unsigned SIZE_W   = ctout_pkg::SIZE_W_DEF,
  parameter int unsigned LEN_W    = ctout_pkg::LEN_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic             setup_evt,
  input  logic             pkt_evt,
  input  logic             drain_valid,
  output logic             drain_ready,
  input  logic [LEN_W-1:0] drain_len,
  output logic             xfer_done,
  output logic             setup_ovf,
  output logic             pkt_err
);

  localparam logic [REG_W-1:0] FMASK = REG_W'(
      ctout_pkg::fmask(SUP_LSB, SUP_W) |
      ctout_pkg::fmask(PKT_LSB, PKT_W) |
      ctout_pkg::fmask(SIZE_LSB, SIZE_W));

  logic [REG_W-1:0]  reg_q;
  logic [REG_W-1:0]  hw_img;
  logic [SUP_W-1:0]  sup_q,  sup_nxt;
  logic [PKT_W-1:0]  pkt_q,  pkt_nxt;
  logic [SIZE_W-1:0] size_q, size_nxt;
  logic              sup_dec, pkt_dec, drain_fire;
  logic              sup_empty, pkt_empty, size_empty;
  logic              done_d, done_q;

  // Software access owns the cycle; the drain source is held off.
  assign drain_ready = !wr_en;
  assign drain_fire  = drain_valid && drain_ready;
  assign sup_dec     = setup_evt && !wr_en;
  assign pkt_dec     = pkt_evt && !wr_en;

  assign sup_q  = reg_q[SUP_LSB  +: SUP_W];
  assign pkt_q  = reg_q[PKT_LSB  +: PKT_W];
  assign size_q = reg_q[SIZE_LSB +: SIZE_W];

  ctout_sat_dec #(.W(SUP_W), .DW(1)) i_sup_dec (
    .cur(sup_q), .dec(sup_dec), .amt(1'b1),
    .nxt(sup_nxt), .empty_hit(sup_empty)
  );

  ctout_sat_dec #(.W(PKT_W), .DW(1)) i_pkt_dec (
    .cur(pkt_q), .dec(pkt_dec), .amt(1'b1),
    .nxt(pkt_nxt), .empty_hit(pkt_empty)
  );

  ctout_sat_dec #(.W(SIZE_W), .DW(LEN_W)) i_size_dec (
    .cur(size_q), .dec(drain_fire), .amt(drain_len),
    .nxt(size_nxt), .empty_hit(size_empty)
  );

  always_comb begin
    hw_img = '0;
    hw_img[SUP_LSB  +: SUP_W]  = sup_nxt;
    hw_img[PKT_LSB  +: PKT_W]  = pkt_nxt;
    hw_img[SIZE_LSB +: SIZE_W] = size_nxt;
  end

  ctout_regfile #(.REG_W(REG_W), .FMASK(FMASK)) i_regfile (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .hw_img(hw_img), .reg_q(reg_q)
  );

  ctout_sticky i_ovf_flag (
    .clk(clk), .rst_n(rst_n), .set(sup_empty), .clr(wr_en), .q(setup_ovf)
  );

  ctout_sticky i_err_flag (
    .clk(clk), .rst_n(rst_n), .set(pkt_empty), .clr(wr_en), .q(pkt_err)
  );

  // Budget leaves nonzero and lands on zero through a drain beat.
  assign done_d = drain_fire && !size_empty && (size_nxt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= done_d;
  end

  assign xfer_done = done_q;
  assign rd_data   = reg_q;

endmodule

// File: rtl/ctout_tracker_chk.sv
module ctout_tracker_chk #(
  parameter int unsigned REG_W    = 32,
  parameter int unsigned SUP_LSB  = 29,
  parameter int unsigned SUP_W    = 2,
  parameter int unsigned PKT_LSB  = 19,
  parameter int unsigned PKT_W    = 1,
  parameter int unsigned SIZE_LSB = 0,
  parameter int unsigned SIZE_W   = 7,
  parameter int unsigned LEN_W    = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [REG_W-1:0] wr_data,
  input logic [REG_W-1:0] rd_data,
  input logic             setup_evt,
  input logic             pkt_evt,
  input logic             drain_valid,
  input logic             drain_ready,
  input logic [LEN_W-1:0] drain_len,
  input logic             xfer_done,
  input logic             setup_ovf,
  input logic             pkt_err
);

  localparam logic [REG_W-1:0] CMASK = REG_W'(
      ctout_pkg::fmask(SUP_LSB, SUP_W) |
      ctout_pkg::fmask(PKT_LSB, PKT_W) |
      ctout_pkg::fmask(SIZE_LSB, SIZE_W));

  logic [SUP_W-1:0]  sup_v;
  logic [SIZE_W-1:0] size_v;
  assign sup_v  = rd_data[SUP_LSB  +: SUP_W];
  assign size_v = rd_data[SIZE_LSB +: SIZE_W];

  // R2
  write_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en) |-> rd_data == ($past(wr_data) & CMASK));

  // R3
  setup_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(wr_en) && $past(setup_evt) && $past(sup_v) != '0)
      |-> sup_v == $past(sup_v) - 1'b1);

  // R4
  ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(wr_en) && $past(setup_ovf)) |-> setup_ovf);

  // R6
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(wr_en) && $past(pkt_err)) |-> pkt_err);

  // R7
  size_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en) |-> size_v <= $past(size_v));

  // R8
  done_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> (size_v == '0) && ($past(size_v) != '0) && $past(drain_valid));

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> !xfer_done);

  // R11
  ready_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |-> drain_ready);

  // R10
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en) |-> !setup_ovf && !pkt_err);

endmodule

bind ctrl_out_tsz_tracker ctout_tracker_chk #(
  .REG_W(REG_W), .SUP_LSB(SUP_LSB), .SUP_W(SUP_W), .PKT_LSB(PKT_LSB),
  .PKT_W(PKT_W), .SIZE_LSB(SIZE_LSB), .SIZE_W(SIZE_W), .LEN_W(LEN_W)
) i_chk (.*);

// File: tb/test_ctrl_out_tsz_tracker.sv
`timescale 1ns/1ps
module test_ctrl_out_tsz_tracker;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        setup_evt = 1'b0;
  logic        pkt_evt = 1'b0;
  logic        drain_valid = 1'b0;
  logic        drain_ready;
  logic [6:0]  drain_len = '0;
  logic        xfer_done;
  logic        setup_ovf;
  logic        pkt_err;

  always #2 clk = ~clk;  // 250 MHz

  ctrl_out_tsz_tracker i_ctrl_out_tsz_tracker (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .setup_evt(setup_evt), .pkt_evt(pkt_evt),
    .drain_valid(drain_valid), .drain_ready(drain_ready),
    .drain_len(drain_len), .xfer_done(xfer_done),
    .setup_ovf(setup_ovf), .pkt_err(pkt_err)
  );

  typedef struct {
    logic [31:0] rd;
    logic        done;
    logic        ovf;
    logic        err;
    logic        rdy;
    string       req;
  } exp_t;

  exp_t exp_q[$];

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // Model state, from the requirements.
  logic [1:0] m_sup = '0;
  logic       m_pkt = 1'b0;
  logic [6:0] m_size = '0;
  logic       m_ovf = 1'b0;
  logic       m_err = 1'b0;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Driver: one cycle of stimulus, expectation pushed for after the edge.
  task automatic cyc(input logic wr, input logic [31:0] wd, input logic st,
                     input logic pk, input logic dv, input logic [6:0] dl,
                     input string req);
    exp_t e;
    logic [6:0] old;
    logic done;
    @(negedge clk);
    wr_en = wr; wr_data = wd; setup_evt = st; pkt_evt = pk;
    drain_valid = dv; drain_len = dl;
    done = 1'b0;
    if (wr) begin
      m_sup = wd[30:29]; m_pkt = wd[19]; m_size = wd[6:0];
      m_ovf = 1'b0; m_err = 1'b0;
    end else begin
      if (st) begin
        if (m_sup == 2'd0) m_ovf = 1'b1;
        else               m_sup = m_sup - 2'd1;
      end
      if (pk) begin
        if (!m_pkt) m_err = 1'b1;
        else        m_pkt = 1'b0;
      end
      if (dv) begin
        old = m_size;
        m_size = (dl >= m_size) ? 7'd0 : m_size - dl;
        done = (old != 7'd0) && (m_size == 7'd0);
      end
    end
    e.rd   = {1'b0, m_sup, 9'd0, m_pkt, 12'd0, m_size};
    e.done = done;
    e.ovf  = m_ovf;
    e.err  = m_err;
    e.rdy  = !wr;
    e.req  = req;
    exp_q.push_back(e);
  endtask

  task automatic idle(input string req);
    cyc(1'b0, 32'd0, 1'b0, 1'b0, 1'b0, 7'd0, req);
  endtask

  task automatic wr(input logic [31:0] d, input string req);
    cyc(1'b1, d, 1'b0, 1'b0, 1'b0, 7'd0, req);
  endtask

  task automatic drain(input logic [6:0] n, input string req);
    cyc(1'b0, 32'd0, 1'b0, 1'b0, 1'b1, n, req);
  endtask

  // Monitor: compare just after each rising edge.
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      check(e.req, "rd_data", rd_data, e.rd);
      check(e.req, "xfer_done", {31'd0, xfer_done}, {31'd0, e.done});
      check(e.req, "setup_ovf", {31'd0, setup_ovf}, {31'd0, e.ovf});
      check(e.req, "pkt_err", {31'd0, pkt_err}, {31'd0, e.err});
      check(e.req, "drain_ready", {31'd0, drain_ready}, {31'd0, e.rdy});
    end
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "rd_data", rd_data, 32'd0);
    check("R1", "xfer_done", {31'd0, xfer_done}, 32'd0);
    check("R1", "flags", {30'd0, setup_ovf, pkt_err}, 32'd0);
    check("R1", "drain_ready", {31'd0, drain_ready}, 32'd1);
    rst_n = 1'b1;
    idle("R1");

    // R2: field placement, reserved bits read zero
    wr(32'hFFFF_FFFF, "R2");
    wr(32'h9FF7_FF80, "R2");
    wr(32'h4008_0015, "R2");

    // R3 / R4: SETUP allowance down to zero, then overflow
    wr(32'h6000_0000, "R3");
    cyc(1'b0, 32'd0, 1'b1, 1'b0, 1'b0, 7'd0, "R3");
    cyc(1'b0, 32'd0, 1'b1, 1'b0, 1'b0, 7'd0, "R3");
    cyc(1'b0, 32'd0, 1'b1, 1'b0, 1'b0, 7'd0, "R3");
    cyc(1'b0, 32'd0, 1'b1, 1'b0, 1'b0, 7'd0, "R4");
    idle("R4");
    idle("R4");

    // R5 / R6: packet count and error flag
    wr(32'h0008_0000, "R10");
    cyc(1'b0, 32'd0, 1'b0, 1'b1, 1'b0, 7'd0, "R5");
    cyc(1'b0, 32'd0, 1'b0, 1'b1, 1'b0, 7'd0, "R6");
    idle("R6");

    // R10: write clears both sticky flags
    cyc(1'b0, 32'd0, 1'b1, 1'b0, 1'b0, 7'd0, "R4");
    wr(32'h6008_0040, "R10");

    // R7 / R8: budget equal to max packet, done per packet
    drain(7'd64, "R8");
    idle("R8");
    drain(7'd5, "R8");
    wr(32'h0000_0040, "R8");
    drain(7'd64, "R8");

    // R7: multi-packet transfer and saturation
    wr(32'h0000_0064, "R7");
    drain(7'd64, "R7");
    drain(7'd36, "R8");
    wr(32'h0000_000A, "R7");
    drain(7'd20, "R7");
    wr(32'h0000_0000, "R8");
    idle("R8");
    wr(32'h0000_007F, "R7");
    drain(7'd0, "R7");
    drain(7'd1, "R7");

    // R9 / R11: write with colliding events, held drain taken after
    wr(32'h2008_0032, "R9");
    cyc(1'b1, 32'h4000_0030, 1'b1, 1'b1, 1'b1, 7'd5, "R9");
    cyc(1'b0, 32'd0, 1'b0, 1'b0, 1'b1, 7'd5, "R11");
    idle("R11");

    @(negedge clk);
    @(negedge clk);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule